// File: doc/BRIEF.md
# Super I/O Configuration Port

This block is the host-facing configuration front end of a Super I/O style device. Software reaches it through two byte-wide I/O ports: an index port that names a configuration register and a data port that reads or writes the named register. Configuration space starts out locked. It opens only when a fixed password byte is written twice back to back on the index port, and it closes again when a relock byte is written there.

Once the port is open, one index is reserved for a logical-device-number register. Every other index is forwarded to one of several per-device register banks, and the logical-device number chooses the bank. The choice persists, so software selects a device once and then makes any number of index/data accesses to it. Bank 0x0D is the bridge bank that carries the host-to-system-bus address, data and trigger registers. The block drives a one-hot bank select, the current index, the write data and single-cycle read and write strobes to the banks. A bank returns its byte combinationally in the cycle of the read strobe. The block answers each claimed read with a registered response one cycle later.

Top module: `siocfg_port`

## Requirements
- R1: After reset the port is locked, the index register is 0x00 and the logical-device number is 0x00.
- R2: The port opens only after the password byte 0xA5 is written to address 0x2E twice in a row. Any other byte written to 0x2E between the two restarts the sequence.
- R3: While the port is locked, a read of 0x2E or 0x2F returns 0xFF. A write to 0x2F drives no bank strobe. Password writes do not load the index register.
- R4: While the port is open, a byte written to 0x2E (other than 0xAA) loads the index register, and a read of 0x2E returns it.
- R5: While open, a write to 0x2F with an index other than 0x07 drives ld_wr_o high for exactly that cycle. In that cycle ld_sel_o is one-hot at bit position equal to the device number, ld_idx_o carries the index and ld_wdata_o carries the byte.
- R6: While open, a read of 0x2F with an index other than 0x07 drives ld_rd_o for that cycle. The selected bank's byte at ld_rdata_i[8*n+7:8*n] is returned on io_rdata_o in the next cycle.
- R7: A write to 0x2F while the index is 0x07 loads the logical-device number and strobes no bank. A read of 0x2F at index 0x07 returns the number. The number persists across later accesses.
- R8: Device number 0x0D selects bank 13, the bridge bank.
- R9: A device number at or above NUM_LD selects no bank. Data-port accesses to it drive no strobe, and reads return 0xFF.
- R10: Writing 0xAA to 0x2E while open relocks the port. The index register and the device number keep their values.
- R11: Reads and writes at any address other than 0x2E and 0x2F are not claimed: io_rvalid_o stays low and no state changes.
- R12: io_rvalid_o is high exactly in the cycle after a read of 0x2E or 0x2F, locked or open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| io_wr_i | input | 1 | I/O write strobe, one cycle |
| io_rd_i | input | 1 | I/O read strobe, one cycle |
| io_addr_i | input | 16 | I/O address |
| io_wdata_i | input | 8 | I/O write byte |
| io_rvalid_o | output | 1 | Read response valid |
| io_rdata_o | output | 8 | Read response byte |
| ld_sel_o | output | NUM_LD | One-hot bank select from the device number |
| ld_idx_o | output | 8 | Current index to the banks |
| ld_wdata_o | output | 8 | Write byte to the banks |
| ld_wr_o | output | 1 | Bank write strobe |
| ld_rd_o | output | 1 | Bank read strobe |
| ld_rdata_i | input | 8*NUM_LD | Per-bank read bytes, bank n in bits 8n+7..8n |

## Verification
A wrong lock state shows at the ports on the next claimed read. The port then returns 0xFF where a register value is due, or returns a value where 0xFF is due, and a stray or missing bank strobe appears in the same cycle as the data-port access. A corrupted index or device number shows on the very next data-port access, through the one-hot select and the index driven to the banks and through the byte read back a cycle later. The bench therefore reads the index and device number back after each change and checks the strobes within the access cycle.

// File: rtl/siocfg_pkg.sv
package siocfg_pkg;
  typedef enum logic [1:0] {
    LK_SHUT = 2'd0,
    LK_HALF = 2'd1,
    LK_OPEN = 2'd2
  } lock_e;
endpackage

// File: rtl/siocfg_lock.sv
module siocfg_lock
  import siocfg_pkg::*;
#(
  parameter logic [7:0] PASS_BYTE  = 8'hA5,
  parameter logic [7:0] RELOCK_BYTE = 8'hAA
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idx_wr_i,
  input  logic [7:0] wdata_i,
  output logic       open_o
);
  lock_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (idx_wr_i) begin
      unique case (st_q)
        LK_SHUT: st_d = (wdata_i == PASS_BYTE) ? LK_HALF : LK_SHUT;
        LK_HALF: st_d = (wdata_i == PASS_BYTE) ? LK_OPEN : LK_SHUT;
        LK_OPEN: st_d = (wdata_i == RELOCK_BYTE) ? LK_SHUT : LK_OPEN;
        default: st_d = LK_SHUT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= LK_SHUT;
    else         st_q <= st_d;
  end

  assign open_o = (st_q == LK_OPEN);

  // R2: opening needs a second password on the half-open step
  a_r2_open_after_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_o) |-> $past(st_q) == LK_HALF && $past(wdata_i) == PASS_BYTE);
  a_r10_relock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_o && idx_wr_i && wdata_i == RELOCK_BYTE) |=> !open_o);
endmodule

// File: rtl/siocfg_regs.sv
module siocfg_regs #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          idx_load_i,
  input  logic          ldn_load_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] index_o,
  output logic [DW-1:0] ldn_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      index_o <= '0;
      ldn_o   <= '0;
    end else begin
      if (idx_load_i) index_o <= wdata_i;
      if (ldn_load_i) ldn_o   <= wdata_i;
    end
  end

  a_r7_ldn_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ldn_load_i |=> $stable(ldn_o));
endmodule

// File: rtl/siocfg_route.sv
module siocfg_route #(
  parameter int NUM_LD = 16,
  parameter int DW     = 8
) (
  input  logic [DW-1:0]        ldn_i,
  input  logic [NUM_LD*DW-1:0] bank_rdata_i,
  output logic [NUM_LD-1:0]    sel_o,
  output logic                 hit_o,
  output logic [DW-1:0]        rdata_o
);
  for (genvar g = 0; g < NUM_LD; g++) begin : g_dec
    assign sel_o[g] = (ldn_i == DW'(g));
  end

  assign hit_o = |sel_o;

  always_comb begin
    rdata_o = '1;
    for (int i = 0; i < NUM_LD; i++) begin
      if (sel_o[i]) rdata_o = bank_rdata_i[i*DW +: DW];
    end
  end

  always_comb a_r9_sel_onehot0: assert ($onehot0(sel_o));
endmodule

// File: rtl/siocfg_port.sv
module siocfg_port
  import siocfg_pkg::*;
#(
  parameter int          NUM_LD      = 16,
  parameter int          AW          = 16,
  parameter logic [15:0] IDX_ADDR    = 16'h002E,
  parameter logic [15:0] DAT_ADDR    = 16'h002F,
  parameter logic [7:0]  PASS_BYTE   = 8'hA5,
  parameter logic [7:0]  RELOCK_BYTE = 8'hAA,
  parameter logic [7:0]  LDN_INDEX   = 8'h07
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 io_wr_i,
  input  logic                 io_rd_i,
  input  logic [AW-1:0]        io_addr_i,
  input  logic [7:0]           io_wdata_i,
  output logic                 io_rvalid_o,
  output logic [7:0]           io_rdata_o,
  output logic [NUM_LD-1:0]    ld_sel_o,
  output logic [7:0]           ld_idx_o,
  output logic [7:0]           ld_wdata_o,
  output logic                 ld_wr_o,
  output logic                 ld_rd_o,
  input  logic [NUM_LD*8-1:0]  ld_rdata_i
);
  localparam int DW = 8;

  logic hit_idx, hit_dat, wr_idx, wr_dat, rd_claim;
  logic open, is_ldn, bank_hit, idx_load, ldn_load;
  logic [DW-1:0] index_q, ldn_q, bank_rdata, rnext;

  assign hit_idx  = (io_addr_i == AW'(IDX_ADDR));
  assign hit_dat  = (io_addr_i == AW'(DAT_ADDR));
  assign wr_idx   = io_wr_i & hit_idx;
  assign wr_dat   = io_wr_i & hit_dat;
  assign rd_claim = io_rd_i & (hit_idx | hit_dat);

  siocfg_lock #(.PASS_BYTE(PASS_BYTE), .RELOCK_BYTE(RELOCK_BYTE)) u_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .idx_wr_i(wr_idx),
    .wdata_i (io_wdata_i),
    .open_o  (open)
  );

  assign idx_load = open & wr_idx & (io_wdata_i != RELOCK_BYTE);
  assign is_ldn   = (index_q == LDN_INDEX);
  assign ldn_load = open & wr_dat & is_ldn;

  siocfg_regs #(.DW(DW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .idx_load_i(idx_load),
    .ldn_load_i(ldn_load),
    .wdata_i   (io_wdata_i),
    .index_o   (index_q),
    .ldn_o     (ldn_q)
  );

  siocfg_route #(.NUM_LD(NUM_LD), .DW(DW)) u_route (
    .ldn_i       (ldn_q),
    .bank_rdata_i(ld_rdata_i),
    .sel_o       (ld_sel_o),
    .hit_o       (bank_hit),
    .rdata_o     (bank_rdata)
  );

  assign ld_idx_o   = index_q;
  assign ld_wdata_o = io_wdata_i;
  assign ld_wr_o    = open & wr_dat & ~is_ldn & bank_hit;
  assign ld_rd_o    = open & io_rd_i & hit_dat & ~is_ldn & bank_hit;

  always_comb begin
    if (!open)         rnext = '1;
    else if (hit_idx)  rnext = index_q;
    else if (is_ldn)   rnext = ldn_q;
    else if (bank_hit) rnext = bank_rdata;
    else               rnext = '1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      io_rvalid_o <= 1'b0;
      io_rdata_o  <= '0;
    end else begin
      io_rvalid_o <= rd_claim;
      if (rd_claim) io_rdata_o <= rnext;
    end
  end

  a_r12_rvalid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_claim |=> io_rvalid_o);
  a_r11_unclaimed_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_claim |=> !io_rvalid_o);
  a_r3_locked_reads_ff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_claim && !open) |=> io_rdata_o == 8'hFF);
  a_r5_wr_single_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_wr_o |-> $onehot(ld_sel_o) && ld_idx_o != LDN_INDEX && !ld_rd_o);
  a_r7_ldn_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ldn_load) |-> !ld_wr_o && !ld_rd_o);
endmodule

// File: tb/tb_siocfg_port.sv
module tb_siocfg_port;
  localparam int NUM_LD = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0] io_wdata = '0;
  logic io_rvalid;
  logic [7:0] io_rdata, ld_idx, ld_wdata;
  logic [NUM_LD-1:0] ld_sel;
  logic ld_wr, ld_rd;
  logic [NUM_LD*8-1:0] ld_rdata;

  int checks = 0, fails = 0;
  logic c_wr, c_rd, c_rv;
  logic [NUM_LD-1:0] c_sel;
  logic [7:0] c_idx, c_wd, c_rdata;

  always #4 clk = ~clk;

  siocfg_port #(.NUM_LD(NUM_LD)) dut (
    .clk_i(clk), .rst_ni(rst_n), .io_wr_i(io_wr), .io_rd_i(io_rd),
    .io_addr_i(io_addr), .io_wdata_i(io_wdata), .io_rvalid_o(io_rvalid),
    .io_rdata_o(io_rdata), .ld_sel_o(ld_sel), .ld_idx_o(ld_idx),
    .ld_wdata_o(ld_wdata), .ld_wr_o(ld_wr), .ld_rd_o(ld_rd), .ld_rdata_i(ld_rdata)
  );

  function automatic logic [7:0] bank_val(input int b, input logic [7:0] idx);
    return 8'(b * 7 + 1) ^ idx;
  endfunction

  always_comb begin
    for (int b = 0; b < NUM_LD; b++) ld_rdata[b*8 +: 8] = bank_val(b, ld_idx);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic wr, input logic rd, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_wr = wr; io_rd = rd; io_addr = a; io_wdata = d;
    #2;
    c_wr = ld_wr; c_rd = ld_rd; c_sel = ld_sel; c_idx = ld_idx; c_wd = ld_wdata;
    @(posedge clk);
    #1;
    c_rv = io_rvalid; c_rdata = io_rdata;
    io_wr = 1'b0; io_rd = 1'b0;
  endtask

  // op 1 = write, 2 = read (data field = expected byte)
  localparam logic [25:0] VEC [14] = '{
    {2'd2, 16'h002F, 8'hFF},  // R1/R3 locked read
    {2'd1, 16'h002E, 8'hA5},  // R2 first password
    {2'd1, 16'h002E, 8'h11},  // R2 breaks sequence
    {2'd1, 16'h002E, 8'hA5},
    {2'd2, 16'h002F, 8'hFF},  // R2 still locked
    {2'd1, 16'h002E, 8'hA5},  // R2 now open
    {2'd2, 16'h002E, 8'h00},  // R1/R3 index untouched by password
    {2'd1, 16'h002E, 8'h07},
    {2'd2, 16'h002F, 8'h00},  // R1 device number reset value
    {2'd1, 16'h002F, 8'h0D},  // R7 select bridge bank
    {2'd2, 16'h002F, 8'h0D},  // R7 readback
    {2'd1, 16'h002E, 8'h30},
    {2'd2, 16'h002E, 8'h30},  // R4 index readback
    {2'd2, 16'h002F, 8'h6C}   // R6/R8 bank 13 byte at index 0x30
  };

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=expired exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 rvalid at reset", 32'(io_rvalid), 0);
    chk("R1 idx at reset", 32'(ld_idx), 0);
    chk("R1 sel at reset", 32'(ld_sel), 1);

    foreach (VEC[i]) begin
      cyc(VEC[i][25:24] == 2'd1, VEC[i][25:24] == 2'd2, VEC[i][23:8], VEC[i][7:0]);
      if (VEC[i][25:24] == 2'd2) begin
        chk($sformatf("R12 vec%0d rvalid", i), 32'(c_rv), 1);
        chk($sformatf("R2 vec%0d rdata", i), 32'(c_rdata), 32'(VEC[i][7:0]));
      end else begin
        chk($sformatf("R3 vec%0d no bank write", i), 32'(c_wr), 0);
      end
    end

    // R8 / R5: write to bridge bank
    cyc(1, 0, 16'h002F, 8'h55);
    chk("R5 wr strobe", 32'(c_wr), 1);
    chk("R8 sel bank13", 32'(c_sel), 32'h2000);
    chk("R5 idx", 32'(c_idx), 32'h30);
    chk("R5 wdata", 32'(c_wd), 32'h55);
    cyc(0, 0, 16'h0000, 8'h00);
    chk("R5 strobe one cycle", 32'(c_wr), 0);
    chk("R12 no rvalid idle", 32'(c_rv), 0);

    // R7: reselect bank 2, no strobe on the select write
    cyc(1, 0, 16'h002E, 8'h07);
    cyc(1, 0, 16'h002F, 8'h02);
    chk("R7 no strobe on ldn write", 32'(c_wr), 0);
    cyc(1, 0, 16'h002E, 8'h10);
    cyc(1, 0, 16'h002E, 8'h10);
    cyc(2'd0, 1, 16'h002F, 8'h00);
    chk("R6 rd strobe", 32'(c_rd), 1);
    chk("R7 sel bank2 persists", 32'(c_sel), 32'h4);
    chk("R6 rdata", 32'(c_rdata), 32'(bank_val(2, 8'h10)));

    // R9: device number outside the banks
    cyc(1, 0, 16'h002E, 8'h07);
    cyc(1, 0, 16'h002F, 8'h20);
    cyc(1, 0, 16'h002E, 8'h10);
    cyc(1, 0, 16'h002F, 8'h77);
    chk("R9 no wr strobe", 32'(c_wr), 0);
    chk("R9 no sel", 32'(c_sel), 0);
    cyc(0, 1, 16'h002F, 8'h00);
    chk("R9 no rd strobe", 32'(c_rd), 0);
    chk("R9 rdata ff", 32'(c_rdata), 32'hFF);
    cyc(1, 0, 16'h002E, 8'h07);
    cyc(0, 1, 16'h002F, 8'h00);
    chk("R7 ldn readback", 32'(c_rdata), 32'h20);

    // R11: other addresses not claimed
    cyc(0, 1, 16'h0080, 8'h00);
    chk("R11 no rvalid", 32'(c_rv), 0);
    cyc(1, 0, 16'h012E, 8'hAA);
    cyc(0, 1, 16'h002E, 8'h00);
    chk("R11 still open, idx kept", 32'(c_rdata), 32'h07);

    // R10: relock, then reopen keeps index and device number
    cyc(1, 0, 16'h002E, 8'hAA);
    cyc(0, 1, 16'h002E, 8'h00);
    chk("R10 locked read", 32'(c_rdata), 32'hFF);
    chk("R12 locked rvalid", 32'(c_rv), 1);
    cyc(1, 0, 16'h002E, 8'hA5);
    cyc(1, 0, 16'h002E, 8'hA5);
    cyc(0, 1, 16'h002F, 8'h00);
    chk("R10 ldn kept", 32'(c_rdata), 32'h20);

    // R1: reset mid-run relocks and clears
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    cyc(0, 1, 16'h002F, 8'h00);
    chk("R1 locked after reset", 32'(c_rdata), 32'hFF);
    chk("R1 idx after reset", 32'(c_idx), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule